// File: doc/BRIEF.md
# Burst Memory Slave

This block is a memory-mapped slave that sits on an AXI4-style bus and is backed by a small on-chip word array. A master writes to it with an address phase followed by a run of data beats. After the last beat the block returns one response. A master reads from it with an address phase, and the block answers with a run of data beats, each carrying its own status. Every channel uses a valid/ready handshake. The write side and the read side have separate state machines and a separate memory port, so both can move data in the same clock cycle.

Bursts are incrementing only. The address phase gives the start byte address, a beat count minus one and a transfer size. The block works out every following beat address by adding the size in bytes. Per-byte write enables choose which bytes of a word change. Any beat whose byte address lies beyond the end of the array is an error beat. An error never shortens a burst. On the write side all beats are still consumed, and the error shows up in the single final response. On the read side the error is marked on each affected beat, and the run continues to its full length.

Top module: `axi_burst_mem`

## Requirements
- R1: Out of reset, `aw_ready` and `ar_ready` are 1 and `w_ready`, `b_valid` and `r_valid` are 0. A beat on any channel is taken only on a rising edge where its valid and its ready are both 1, so data driven while `w_valid` is 0 never reaches the memory.
- R2: Beat i of a burst uses byte address start + i * 2^size. The word index is the byte address divided by DATA_W/8. Sizes below full width step through the lanes of one word.
- R3: Bit b of `w_strb` enables byte lane b (bits 8b+7..8b) of the addressed word. Lanes whose strobe bit is 0 keep their old value.
- R4: A write burst closes on the first beat that has `w_last` = 1, or on beat `aw_len`+1, whichever comes first. After that `w_ready` is 0, and exactly one response is raised on `b_valid`, which drops after one `b_ready` handshake.
- R5: Once `b_valid` is 1 it stays 1, with `b_resp` unchanged, until `b_ready` is seen.
- R6: A write beat whose byte address is at or above DEPTH*DATA_W/8 leaves the memory unchanged. If any beat of the burst was such a beat, `b_resp` is 2'b10, and otherwise it is 2'b00.
- R7: A read burst returns exactly `ar_len`+1 beats. `r_last` is 1 on the final beat only, including when the burst has a single beat. After that, `r_valid` is 0 and `ar_ready` is 1.
- R8: Each read beat has its own `r_resp`: 2'b00 with the addressed word when the beat is in range, and 2'b10 with all-zero `r_data` when it is out of range.
- R9: While `r_valid` is 1 and `r_ready` is 0, `r_data`, `r_resp` and `r_last` hold their values.
- R10: A new write address is taken only after the previous write response has been handshaken. A new read address is taken only after the previous read's last beat has been handshaken.
- R11: Write beats and read beats can both be handshaken in the same clock cycle, and each produces its correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_len | input | LEN_W | Write beat count minus one |
| aw_size | input | 3 | Write beat size, log2 of bytes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| w_data | input | DATA_W | Write beat data |
| w_strb | input | DATA_W/8 | Write byte enables |
| w_last | input | 1 | Final write beat marker |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat ready |
| b_resp | output | 2 | Write burst status |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_len | input | LEN_W | Read beat count minus one |
| ar_size | input | 3 | Read beat size, log2 of bytes |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| r_data | output | DATA_W | Read beat data |
| r_resp | output | 2 | Read beat status |
| r_last | output | 1 | Final read beat marker |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat ready |

## Verification
A write data beat and a read data beat can be handshaken on the same edge, because the two paths share only the memory array. The bench starts a four-beat write and a four-beat read on separate word ranges in parallel threads. A monitor records any falling edge where `w_valid`, `w_ready`, `r_valid` and `r_ready` are all high. The overlap is judged on three points: the monitor must have fired, every read beat must match the bench's byte model as it stood before the write, and a later read-back must show the written words exactly.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   typedef enum logic [1:0] {
      WS_ADDR,
      WS_DATA,
      WS_RESP
   } wr_state_e;

   typedef enum logic {
      RS_ADDR,
      RS_DATA
   } rd_state_e;

endpackage

// File: rtl/abm_store.sv
module abm_store #(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int STRB_W        = DATA_W / 8,
   localparam int IDX_W         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rows [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;

      assign hit = we && (widx == IDX_W'(w));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (hit) begin
               for (int b = 0; b < STRB_W; b++) begin
                  if (wstrb[b]) word_q[b*8 +: 8] <= wdata[b*8 +: 8];
               end
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) begin
               for (int b = 0; b < STRB_W; b++) begin
                  if (wstrb[b]) word_q[b*8 +: 8] <= wdata[b*8 +: 8];
               end
            end
         end
      end

      assign rows[w] = word_q;
   end

   assign rdata = rows[ridx];

endmodule

// File: rtl/abm_wr_path.sv
module abm_wr_path
   import axi_burst_mem_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 8,
   parameter int DEPTH  = 16,
   localparam int STRB_W = DATA_W / 8,
   localparam int OFF_W  = $clog2(STRB_W),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic [2:0]        aw_size,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              w_last,
   input  logic              w_valid,
   output logic              w_ready,
   output logic [1:0]        b_resp,
   output logic              b_valid,
   input  logic              b_ready,
   output logic              mem_we,
   output logic [IDX_W-1:0]  mem_widx,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [STRB_W-1:0] mem_wstrb
);

   wr_state_e         st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [2:0]        size_q;
   logic              err_q;
   logic [1:0]        bresp_q;
   logic              w_fire;
   logic              in_rng;
   logic              closing;

   assign aw_ready = (st_q == WS_ADDR);
   assign w_ready  = (st_q == WS_DATA);
   assign b_valid  = (st_q == WS_RESP);
   assign b_resp   = bresp_q;

   assign w_fire  = w_valid && w_ready;
   assign in_rng  = (addr_q[ADDR_W-1:OFF_W+IDX_W] == '0);
   assign closing = w_last || (cnt_q == len_q);

   assign mem_we    = w_fire && in_rng;
   assign mem_widx  = addr_q[OFF_W +: IDX_W];
   assign mem_wdata = w_data;
   assign mem_wstrb = w_strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WS_ADDR;
         addr_q  <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         size_q  <= '0;
         err_q   <= 1'b0;
         bresp_q <= RESP_OKAY;
      end else begin
         case (st_q)
            WS_ADDR: if (aw_valid) begin
               addr_q <= aw_addr;
               len_q  <= aw_len;
               size_q <= aw_size;
               cnt_q  <= '0;
               err_q  <= 1'b0;
               st_q   <= WS_DATA;
            end
            WS_DATA: if (w_fire) begin
               addr_q <= addr_q + (ADDR_W'(1) << size_q);
               cnt_q  <= cnt_q + LEN_W'(1);
               if (closing) begin
                  bresp_q <= (err_q || !in_rng) ? RESP_SLVERR : RESP_OKAY;
                  st_q    <= WS_RESP;
               end else begin
                  err_q <= err_q || !in_rng;
               end
            end
            WS_RESP: if (b_ready) st_q <= WS_ADDR;
            default: st_q <= WS_ADDR;
         endcase
      end
   end

   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && !b_ready) |=> (b_valid && $stable(b_resp))); // R5
   AST_ONE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && b_ready) |=> !b_valid); // R4
   AST_AW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_valid && aw_ready) |=> !aw_ready); // R10
   AST_W_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      w_ready |-> (cnt_q <= len_q)); // R4

endmodule

// File: rtl/abm_rd_path.sv
module abm_rd_path
   import axi_burst_mem_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 8,
   parameter int DEPTH  = 16,
   localparam int STRB_W = DATA_W / 8,
   localparam int OFF_W  = $clog2(STRB_W),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   input  logic [2:0]        ar_size,
   input  logic              ar_valid,
   output logic              ar_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [IDX_W-1:0]  mem_ridx,
   input  logic [DATA_W-1:0] mem_rdata
);

   rd_state_e         st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [2:0]        size_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] look_addr;
   logic              look_ok;
   logic              r_fire;

   assign ar_ready = (st_q == RS_ADDR);
   assign r_valid  = (st_q == RS_DATA);
   assign r_last   = (cnt_q == len_q);
   assign r_data   = data_q;
   assign r_resp   = err_q ? RESP_SLVERR : RESP_OKAY;
   assign r_fire   = r_valid && r_ready;

   assign next_addr = addr_q + (ADDR_W'(1) << size_q);
   assign look_addr = (st_q == RS_ADDR) ? ar_addr : next_addr;
   assign look_ok   = (look_addr[ADDR_W-1:OFF_W+IDX_W] == '0);
   assign mem_ridx  = look_addr[OFF_W +: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RS_ADDR;
         addr_q <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         size_q <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            RS_ADDR: if (ar_valid) begin
               addr_q <= ar_addr;
               len_q  <= ar_len;
               size_q <= ar_size;
               cnt_q  <= '0;
               data_q <= look_ok ? mem_rdata : '0;
               err_q  <= !look_ok;
               st_q   <= RS_DATA;
            end
            RS_DATA: if (r_fire) begin
               if (r_last) begin
                  st_q <= RS_ADDR;
               end else begin
                  addr_q <= next_addr;
                  cnt_q  <= cnt_q + LEN_W'(1);
                  data_q <= look_ok ? mem_rdata : '0;
                  err_q  <= !look_ok;
               end
            end
            default: st_q <= RS_ADDR;
         endcase
      end
   end

   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp) && $stable(r_last))); // R9
   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_resp == RESP_SLVERR) |-> (r_data == '0)); // R8
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_ready && r_last) |=> (!r_valid && ar_ready)); // R7
   AST_AR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid && ar_ready) |=> !ar_ready); // R10

endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
   import axi_burst_mem_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 32,
   parameter int LEN_W          = 8,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int STRB_W        = DATA_W / 8,
   localparam int OFF_W         = $clog2(STRB_W),
   localparam int IDX_W         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic [2:0]        aw_size,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              w_last,
   input  logic              w_valid,
   output logic              w_ready,
   output logic [1:0]        b_resp,
   output logic              b_valid,
   input  logic              b_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   input  logic [2:0]        ar_size,
   input  logic              ar_valid,
   output logic              ar_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last,
   output logic              r_valid,
   input  logic              r_ready
);

   if (DATA_W < 8 || (DATA_W % 8) != 0 || (STRB_W & (STRB_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the memory byte span");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   logic              mem_we;
   logic [IDX_W-1:0]  mem_widx;
   logic [DATA_W-1:0] mem_wdata;
   logic [STRB_W-1:0] mem_wstrb;
   logic [IDX_W-1:0]  mem_ridx;
   logic [DATA_W-1:0] mem_rdata;

   abm_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(mem_we), .widx(mem_widx), .wdata(mem_wdata), .wstrb(mem_wstrb),
      .ridx(mem_ridx), .rdata(mem_rdata)
   );

   abm_wr_path #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
   ) u_wr (
      .clk(clk), .rst_n(rst_n),
      .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size),
      .aw_valid(aw_valid), .aw_ready(aw_ready),
      .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
      .w_valid(w_valid), .w_ready(w_ready),
      .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
      .mem_we(mem_we), .mem_widx(mem_widx),
      .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
   );

   abm_rd_path #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
   ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
      .ar_valid(ar_valid), .ar_ready(ar_ready),
      .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
      .r_valid(r_valid), .r_ready(r_ready),
      .mem_ridx(mem_ridx), .mem_rdata(mem_rdata)
   );

   AST_STORE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (w_valid && w_ready)); // R1
   AST_RESP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid |-> (b_resp == RESP_OKAY || b_resp == RESP_SLVERR)); // R6

endmodule

// File: tb/axi_burst_mem_bench.sv
module axi_burst_mem_bench;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int LEN_W  = 8;
   localparam int DEPTH  = 16;
   localparam int NBYTES = DEPTH * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] aw_addr = '0;
   logic [LEN_W-1:0]  aw_len = '0;
   logic [2:0]        aw_size = 3'd2;
   logic              aw_valid = 1'b0;
   logic              aw_ready;
   logic [DATA_W-1:0] w_data = '0;
   logic [3:0]        w_strb = '0;
   logic              w_last = 1'b0;
   logic              w_valid = 1'b0;
   logic              w_ready;
   logic [1:0]        b_resp;
   logic              b_valid;
   logic              b_ready = 1'b0;
   logic [ADDR_W-1:0] ar_addr = '0;
   logic [LEN_W-1:0]  ar_len = '0;
   logic [2:0]        ar_size = 3'd2;
   logic              ar_valid = 1'b0;
   logic              ar_ready;
   logic [DATA_W-1:0] r_data;
   logic [1:0]        r_resp;
   logic              r_last;
   logic              r_valid;
   logic              r_ready = 1'b0;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  both_seen = 1'b0;
   logic [7:0] model [NBYTES];

   always #4 clk = ~clk;

   axi_burst_mem #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
   ) u_axi_burst_mem (
      .clk(clk), .rst_n(rst_n),
      .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size),
      .aw_valid(aw_valid), .aw_ready(aw_ready),
      .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
      .w_valid(w_valid), .w_ready(w_ready),
      .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
      .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
      .ar_valid(ar_valid), .ar_ready(ar_ready),
      .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
      .r_valid(r_valid), .r_ready(r_ready)
   );

   always @(negedge clk) begin
      if (w_valid && w_ready && r_valid && r_ready) both_seen = 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word(input logic [ADDR_W-1:0] a);
      logic [31:0] v = '0;
      if (a < NBYTES) begin
         for (int b = 0; b < 4; b++) v[b*8 +: 8] = model[{a[ADDR_W-1:2], 2'b00} + b];
      end
      return v;
   endfunction

   function automatic logic [3:0] lane_mask(input logic [ADDR_W-1:0] a, input logic [2:0] sz);
      logic [3:0] m;
      m = (sz >= 3'd2) ? 4'hF : ((sz == 3'd1) ? 4'b0011 : 4'b0001);
      if (sz < 3'd2) m = m << a[1:0];
      return m;
   endfunction

   // Writes nbeats beats; w_last on the final one when mark_last is set.
   task automatic wr_burst(input logic [ADDR_W-1:0] addr, input int len, input logic [2:0] sz,
                           input int nbeats, input bit mark_last, input logic [3:0] mask,
                           input logic [31:0] seed, input int gap, input int bwait,
                           input logic [1:0] exp_resp, input string tag);
      logic [ADDR_W-1:0] a = addr;
      @(negedge clk);
      aw_addr = addr; aw_len = LEN_W'(len); aw_size = sz; aw_valid = 1'b1;
      while (!aw_ready) @(negedge clk);
      @(negedge clk);
      aw_valid = 1'b0;
      chk(aw_ready == 1'b0, {tag, " R10 aw_ready low during burst"}, 32'(aw_ready), 32'd0);
      for (int i = 0; i < nbeats; i++) begin
         logic [31:0] d = seed ^ (32'h11111111 * i);
         logic [3:0]  s = lane_mask(a, sz) & mask;
         for (int g = 0; g < gap; g++) begin
            w_valid = 1'b0; w_data = 32'hDEADBEEF; w_strb = 4'hF; w_last = 1'b1;
            @(negedge clk);
         end
         w_data = d; w_strb = s; w_last = mark_last && (i == nbeats - 1); w_valid = 1'b1;
         while (!w_ready) @(negedge clk);
         if (a < NBYTES) begin
            for (int b = 0; b < 4; b++)
               if (s[b]) model[{a[ADDR_W-1:2], 2'b00} + b] = d[b*8 +: 8];
         end
         a = a + (ADDR_W'(1) << sz);
         @(negedge clk);
      end
      w_valid = 1'b0; w_last = 1'b0;
      chk(w_ready == 1'b0, {tag, " R4 w_ready low after burst close"}, 32'(w_ready), 32'd0);
      while (!b_valid) @(negedge clk);
      chk(b_resp == exp_resp, {tag, " R6 b_resp"}, 32'(b_resp), 32'(exp_resp));
      for (int k = 0; k < bwait; k++) begin
         @(negedge clk);
         chk(b_valid && b_resp == exp_resp, {tag, " R5 response held"}, {b_valid, b_resp}, {1'b1, exp_resp});
      end
      b_ready = 1'b1;
      @(negedge clk);
      b_ready = 1'b0;
      chk(!b_valid && aw_ready, {tag, " R4 single response then idle"}, {b_valid, aw_ready}, 32'b01);
   endtask

   task automatic rd_burst(input logic [ADDR_W-1:0] addr, input int len, input logic [2:0] sz,
                           input bit stall, input string tag);
      logic [ADDR_W-1:0] a = addr;
      int beats = 0;
      int cyc = 0;
      bit held = 1'b0;
      logic [34:0] prev = '0;
      @(negedge clk);
      ar_addr = addr; ar_len = LEN_W'(len); ar_size = sz; ar_valid = 1'b1;
      while (!ar_ready) @(negedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      chk(ar_ready == 1'b0, {tag, " R10 ar_ready low during burst"}, 32'(ar_ready), 32'd0);
      while (beats <= len && cyc < 200) begin
         r_ready = stall ? cyc[0] : 1'b1;
         if (held) chk(r_valid && {r_data, r_resp, r_last} == prev, {tag, " R9 beat held"},
                       r_data, prev[34:3]);
         held = 1'b0;
         if (r_valid && r_ready) begin
            logic ok_rng = (a < NBYTES);
            chk(r_data == model_word(a), {tag, " R8 beat data"}, r_data, model_word(a));
            chk(r_resp == (ok_rng ? 2'b00 : 2'b10), {tag, " R8 beat resp"}, 32'(r_resp),
                ok_rng ? 32'd0 : 32'd2);
            chk(r_last == (beats == len), {tag, " R7 r_last"}, 32'(r_last), 32'(beats == len));
            beats++;
            a = a + (ADDR_W'(1) << sz);
         end else if (r_valid) begin
            held = 1'b1;
            prev = {r_data, r_resp, r_last};
         end
         cyc++;
         @(negedge clk);
      end
      r_ready = 1'b0;
      chk(beats == len + 1, {tag, " R7 beat count"}, 32'(beats), 32'(len + 1));
      chk(!r_valid && ar_ready, {tag, " R7 idle after last"}, {r_valid, ar_ready}, 32'b01);
   endtask

   task automatic t_reset;
      chk(aw_ready && ar_ready && !w_ready && !b_valid && !r_valid, "R1 reset state",
          {aw_ready, ar_ready, w_ready, b_valid, r_valid}, 32'b11000);
   endtask

   task automatic t_single;
      wr_burst(16'h0004, 0, 3'd2, 1, 1'b1, 4'hF, 32'hA5A50001, 0, 0, 2'b00, "single");
      rd_burst(16'h0004, 0, 3'd2, 1'b0, "single R7");
   endtask

   task automatic t_burst;
      wr_burst(16'h0010, 3, 3'd2, 4, 1'b1, 4'hF, 32'h12345678, 0, 0, 2'b00, "burst4 R2");
      rd_burst(16'h0010, 3, 3'd2, 1'b1, "burst4 R2 R9");
   endtask

   task automatic t_strobe;
      wr_burst(16'h0010, 1, 3'd2, 2, 1'b1, 4'b0101, 32'hCAFEF00D, 0, 0, 2'b00, "strobe R3");
      rd_burst(16'h0010, 1, 3'd2, 1'b0, "strobe R3");
   endtask

   task automatic t_narrow;
      wr_burst(16'h0020, 3, 3'd1, 4, 1'b1, 4'hF, 32'h0BADC0DE, 0, 0, 2'b00, "narrow R2 R3");
      rd_burst(16'h0020, 1, 3'd2, 1'b0, "narrow R2");
   endtask

   task automatic t_close;
      wr_burst(16'h0030, 3, 3'd2, 2, 1'b1, 4'hF, 32'h77770000, 0, 0, 2'b00, "early last R4");
      wr_burst(16'h0000, 2, 3'd2, 3, 1'b0, 4'hF, 32'h55550000, 0, 0, 2'b00, "count close R4");
      rd_burst(16'h0000, 3, 3'd2, 1'b0, "close readback R4");
      rd_burst(16'h0030, 3, 3'd2, 1'b0, "early readback R4");
   endtask

   task automatic t_error;
      wr_burst(16'h0038, 3, 3'd2, 4, 1'b1, 4'hF, 32'hE0E0E0E0, 0, 0, 2'b10, "err write R6");
      rd_burst(16'h0038, 3, 3'd2, 1'b0, "err read R8");
      rd_burst(16'h0100, 0, 3'd2, 1'b0, "err single read R8");
   endtask

   task automatic t_bhold;
      wr_burst(16'h0008, 0, 3'd2, 1, 1'b1, 4'hF, 32'h0F0F0F0F, 0, 4, 2'b00, "b hold R5");
   endtask

   task automatic t_gate;
      wr_burst(16'h000C, 1, 3'd2, 2, 1'b1, 4'hF, 32'h31415926, 3, 0, 2'b00, "valid gate R1");
      rd_burst(16'h000C, 1, 3'd2, 1'b0, "valid gate R1");
   endtask

   task automatic t_concurrent;
      both_seen = 1'b0;
      fork
         wr_burst(16'h0000, 3, 3'd2, 4, 1'b1, 4'hF, 32'h9ABC0000, 0, 0, 2'b00, "concurrent wr R11");
         begin
            @(negedge clk);
            rd_burst(16'h0020, 3, 3'd2, 1'b0, "concurrent rd R11");
         end
      join
      chk(both_seen, "R11 same-cycle write and read beats", 32'(both_seen), 32'd1);
      rd_burst(16'h0000, 3, 3'd2, 1'b0, "concurrent readback R11");
   endtask

   initial begin
      for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_burst();
      t_strobe();
      t_narrow();
      t_close();
      t_error();
      t_bhold();
      t_gate();
      t_concurrent();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule